// File: doc/BRIEF.md
# Time-Code Frame Readout Controller

This block sits on the host side of a radio time-code receiver and collects the pre-decoded frames the receiver offers over a three-wire link. The receiver raises a ready line. After a wake-up delay the controller drives read strobes on a transfer line and samples a serial data line once per strobe. It first collects a 4-bit header: three bits that name the received protocol, then a control bit that also serves as the signal flag. If the control bit is 1 it goes on to read the 60 per-second bits of the minute. Otherwise it stops after the header.

When a read completes, the protocol code, the signal flag and the minute word appear in parallel and stay until the next completed read. A one-cycle done pulse marks the update. If the receiver withdraws the ready line before the read is over, the controller stops strobing, pulses an error flag and leaves the outputs untouched. Strobe phase lengths and the wake-up delay are counted in system clocks. Both are set by parameters, and the defaults give 50 µs phases and a 1 ms wake-up at 125 MHz.

Top module: `tsig_frame_reader`

## Requirements
- R1: After reset the strobe is low, done and error are low, and the protocol code, signal flag, minute word and valid flag are all 0.
- R2: A read starts only on a rising edge of the ready line. The first strobe rise comes exactly WAKE_CYC + HALF_CYC clocks after the clock edge that first sees ready high, so the wake-up delay is never shorter than WAKE_CYC.
- R3: Every strobe high phase lasts exactly HALF_CYC clocks, and every strobe low phase lasts at least HALF_CYC clocks.
- R4: The first three bits read go to the protocol code with the first bit in bit 2, the second in bit 1 and the third in bit 0. The fourth bit is the signal flag.
- R5: If the fourth bit is 1, exactly 64 strobes are given in total. The valid flag becomes 1 and the minute word holds the 60 data bits, with the first of them (second 0) in bit 59 and the last (second 59) in bit 0.
- R6: If the fourth bit is 0, exactly 4 strobes are given. The valid flag becomes 0 and the minute word becomes 0.
- R7: The level on the data line before the first strobe of a read has no effect. Each bit is taken one clock after a strobe rise.
- R8: Done is a one-cycle pulse on the clock edge that ends the last strobe's high phase, 1 + WAKE_CYC + 2·HALF_CYC·N clocks after the read began, where N is the number of strobes. The outputs change only on that edge and then hold.
- R9: If ready is low while a read is in its wake-up or strobing phase, the controller pulses error for one cycle, gives no done, keeps the previous outputs, and holds the strobe low from the second cycle on.
- R10: If ready is seen low on the very edge at which the read would complete, the abort wins: error pulses and done does not.
- R11: While ready simply stays high after a completed read, no further strobes and no second done occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rdy_i | input | 1 | Receiver ready line, synchronous to clk |
| ser_dat_i | input | 1 | Serial data from the receiver, synchronous to clk |
| rd_strobe_o | output | 1 | Read strobe to the receiver |
| proto_o | output | 3 | Protocol code of the last completed read |
| sig_o | output | 1 | Signal/control flag of the last completed read |
| minute_o | output | DATA_BITS | Minute word, second 0 in the top bit |
| minute_valid_o | output | 1 | 1 when the last read carried the minute word |
| done_o | output | 1 | One-cycle pulse when a read completes |
| err_o | output | 1 | One-cycle pulse when a read is aborted |

## Verification
Completion and abort can fall on the same clock edge: the edge that ends the last strobe's high phase may also be the first edge that sees the ready line low. The bench provokes this on a header-only read by counting clocks from the ready rise. It drops ready so that it is first sampled low exactly on the predicted completion edge, and expects an error pulse, no done and unchanged outputs. It then repeats the read with the drop one clock later and expects a normal done with no error.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int HDR_BITS   = 4;
    localparam int PROTO_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAKE = 2'd1,
        ST_XFER = 2'd2,
        ST_TAIL = 2'd3
    } state_t;

endpackage

// File: rtl/tfr_strobe_gen.sv
module tfr_strobe_gen #(
    parameter int HALF_CYC = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe_o,
    output logic sample_o,
    output logic phase_end_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strb;
    } sg_t;

    sg_t d, q;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt  = '0;
            d.strb = 1'b0;
        end else if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.strb = ~q.strb;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign strobe_o    = q.strb;
    assign sample_o    = run && q.strb && (q.cnt == '0);
    assign phase_end_o = run && q.strb && (q.cnt == LAST);

endmodule

// File: rtl/tfr_wake_timer.sv
module tfr_wake_timer #(
    parameter int WAKE_CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired_o
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)                cnt_d = '0;
        else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run && (cnt_q == LAST);

endmodule

// File: rtl/tfr_shifter.sv
module tfr_shifter
    import tfr_pkg::*;
#(
    parameter int DATA_BITS = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift,
    input  logic                 bit_in,
    output logic [HDR_BITS-1:0]  hdr_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic [$clog2(HDR_BITS+DATA_BITS+1)-1:0] cnt_o
);
    localparam int TOTAL = HDR_BITS + DATA_BITS;
    localparam int NW    = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [HDR_BITS-1:0]  hdr;
        logic [DATA_BITS-1:0] data;
        logic [NW-1:0]        cnt;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (shift) begin
            if (q.cnt < NW'(HDR_BITS)) d.hdr  = {q.hdr[HDR_BITS-2:0], bit_in};
            else                       d.data = {q.data[DATA_BITS-2:0], bit_in};
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hdr_o  = q.hdr;
    assign data_o = q.data;
    assign cnt_o  = q.cnt;

endmodule

// File: rtl/tsig_frame_reader.sv
module tsig_frame_reader
    import tfr_pkg::*;
#(
    parameter int HALF_CYC  = 6250,
    parameter int WAKE_CYC  = 125000,
    parameter int DATA_BITS = 60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_rdy_i,
    input  logic                  ser_dat_i,
    output logic                  rd_strobe_o,
    output logic [PROTO_BITS-1:0] proto_o,
    output logic                  sig_o,
    output logic [DATA_BITS-1:0]  minute_o,
    output logic                  minute_valid_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int TOTAL = HDR_BITS + DATA_BITS;
    localparam int NW    = $clog2(TOTAL + 1);

    typedef struct packed {
        state_t                st;
        logic                  rdy;
        logic                  done;
        logic                  err;
        logic [PROTO_BITS-1:0] proto;
        logic                  sig;
        logic                  valid;
        logic [DATA_BITS-1:0]  minute;
    } ctl_t;

    ctl_t d, q;

    logic                 wake_done, sample, phase_end, strobe;
    logic                 clr, shift;
    logic [HDR_BITS-1:0]  hdr;
    logic [DATA_BITS-1:0] data;
    logic [NW-1:0]        bit_cnt;

    tfr_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.st == ST_WAKE),
        .expired_o (wake_done)
    );

    tfr_strobe_gen #(.HALF_CYC(HALF_CYC)) u_strb (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         ((q.st == ST_XFER) || (q.st == ST_TAIL)),
        .strobe_o    (strobe),
        .sample_o    (sample),
        .phase_end_o (phase_end)
    );

    tfr_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .shift  (shift),
        .bit_in (ser_dat_i),
        .hdr_o  (hdr),
        .data_o (data),
        .cnt_o  (bit_cnt)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        d.rdy  = frame_rdy_i;
        clr    = 1'b0;
        shift  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (frame_rdy_i && !q.rdy) begin
                    d.st = ST_WAKE;
                    clr  = 1'b1;
                end
            end
            ST_WAKE: begin
                if (!frame_rdy_i) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end else if (wake_done) begin
                    d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (!frame_rdy_i) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end else if (sample) begin
                    shift = 1'b1;
                    if ((bit_cnt == NW'(HDR_BITS - 1)) && !ser_dat_i) d.st = ST_TAIL;
                    else if (bit_cnt == NW'(TOTAL - 1))               d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                // abort is checked before completion: it wins on a shared edge
                if (!frame_rdy_i) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end else if (phase_end) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.proto  = hdr[HDR_BITS-1:1];
                    d.sig    = hdr[0];
                    d.valid  = (bit_cnt == NW'(TOTAL));
                    d.minute = (bit_cnt == NW'(TOTAL)) ? data : '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_strobe_o    = strobe;
    assign proto_o        = q.proto;
    assign sig_o          = q.sig;
    assign minute_o       = q.minute;
    assign minute_valid_o = q.valid;
    assign done_o         = q.done;
    assign err_o          = q.err;

endmodule

// File: rtl/tfr_frame_reader_chk.sv
module tfr_frame_reader_chk #(
    parameter int HALF_CYC = 6250,
    parameter int WAKE_CYC = 125000
) (
    input logic clk,
    input logic rst_n,
    input logic frame_rdy_i,
    input logic rd_strobe_o,
    input logic minute_valid_o,
    input logic done_o,
    input logic err_o
);
    localparam int HW = $clog2(HALF_CYC + 2);
    localparam int WW = $clog2(WAKE_CYC + 2);

    logic [HW-1:0] hi_cnt, lo_cnt;
    logic [WW-1:0] rdy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            rdy_cnt <= '0;
        end else begin
            if (!rd_strobe_o)                    hi_cnt <= '0;
            else if (hi_cnt != HW'(HALF_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;
            if (rd_strobe_o)                     lo_cnt <= '0;
            else if (lo_cnt != HW'(HALF_CYC))    lo_cnt <= lo_cnt + 1'b1;
            if (!frame_rdy_i)                    rdy_cnt <= '0;
            else if (rdy_cnt != WW'(WAKE_CYC))   rdy_cnt <= rdy_cnt + 1'b1;
        end
    end

    assert_wake_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe_o) |-> (rdy_cnt >= WW'(WAKE_CYC)));

    assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe_o) && !$past(err_o)) |-> (hi_cnt == HW'(HALF_CYC)));

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe_o) |-> (lo_cnt >= HW'(HALF_CYC)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_valid_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(minute_valid_o) |-> done_o);

    assert_quiet_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_rdy_i && !$past(frame_rdy_i) && !$past(frame_rdy_i, 2)) |-> !rd_strobe_o);

    assert_abort_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);

endmodule

bind tsig_frame_reader tfr_frame_reader_chk #(
    .HALF_CYC (HALF_CYC),
    .WAKE_CYC (WAKE_CYC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_rdy_i    (frame_rdy_i),
    .rd_strobe_o    (rd_strobe_o),
    .minute_valid_o (minute_valid_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/sim_tsig_frame_reader.sv
module sim_tsig_frame_reader;
    localparam int HALF = 4;
    localparam int WAKE = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy = 1'b0;
    logic        sdat = 1'b0;
    logic        strobe;
    logic [2:0]  proto;
    logic        sig;
    logic [59:0] minute;
    logic        valid, done, err;

    tsig_frame_reader #(.HALF_CYC(HALF), .WAKE_CYC(WAKE), .DATA_BITS(60)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_rdy_i(rdy), .ser_dat_i(sdat),
        .rd_strobe_o(strobe), .proto_o(proto), .sig_o(sig), .minute_o(minute),
        .minute_valid_o(valid), .done_o(done), .err_o(err)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    logic [63:0] fbits;
    int flen, fidx, rises, first_rise, done_cyc, n_done, n_err;
    int hi_run = 0, lo_run = 0, width_bad = 0;
    logic ignore_w = 1'b0;
    logic strb_prev = 1'b0;

    // receiver model and monitor, all at the falling clock edge
    always @(negedge clk) begin
        if (strobe && !strb_prev) begin
            rises++;
            if (rises == 1) first_rise = cyc;
            if (lo_run < HALF) width_bad++;
            hi_run = 1;
            if (fidx < flen) begin
                sdat = fbits[63 - fidx];
                fidx++;
            end
        end else if (strobe) begin
            hi_run++;
        end
        if (!strobe && strb_prev) begin
            if (hi_run != HALF && !ignore_w) width_bad++;
            lo_run = 1;
        end else if (!strobe) begin
            lo_run++;
        end
        strb_prev = strobe;
        if (done) begin n_done++; done_cyc = cyc; end
        if (err) n_err++;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [59:0] exp_minute(input logic s, input logic [59:0] dd);
        return s ? dd : 60'd0;
    endfunction

    function automatic int exp_done_delay(input int n);
        return 1 + WAKE + 2 * HALF * n;
    endfunction

    task automatic arm(input logic [2:0] p, input logic s, input logic [59:0] dd);
        fbits = {p, s, dd};
        flen  = s ? 64 : 4;
        fidx  = 0;
        rises = 0;
        n_done = 0;
        n_err  = 0;
        first_rise = -1;
        done_cyc   = -1;
    endtask

    task automatic do_read(input logic [2:0] p, input logic s, input logic [59:0] dd,
                           input logic set_pre, input logic pre, input string tag);
        int c0, t;
        arm(p, s, dd);
        if (set_pre) sdat = pre;
        rdy = 1'b1;
        c0 = cyc;
        t = 0;
        while (n_done == 0 && n_err == 0 && t < 2000) begin step(); t++; end
        check({tag, " R8 one done"}, 64'(n_done), 64'd1);
        check({tag, " R9 no err"}, 64'(n_err), 64'd0);
        check({tag, " R2 first rise"}, 64'(first_rise - c0), 64'(1 + WAKE + HALF));
        check({tag, s ? " R5 strobes" : " R6 strobes"}, 64'(rises), 64'(flen));
        check({tag, " R8 done time"}, 64'(done_cyc - c0), 64'(exp_done_delay(flen)));
        check({tag, " R4 proto"}, 64'(proto), 64'(p));
        check({tag, " R4 sig"}, 64'(sig), 64'(s));
        check({tag, s ? " R5 valid" : " R6 valid"}, 64'(valid), 64'(s));
        check({tag, s ? " R5 minute" : " R6 minute"}, 64'(minute), 64'(exp_minute(s, dd)));
        for (int i = 0; i < 30; i++) step();
        check({tag, " R11 no re-read strobes"}, 64'(rises), 64'(flen));
        check({tag, " R11 no second done"}, 64'(n_done), 64'd1);
        check({tag, " R8 outputs hold"}, {proto, sig, minute}, {p, s, exp_minute(s, dd)});
        rdy = 1'b0;
        for (int i = 0; i < 5; i++) step();
    endtask

    task automatic do_drop(input logic [2:0] p, input logic s, input logic [59:0] dd,
                           input int off, input logic exp_err, input string tag);
        int c0;
        logic [63:0] prev_out;
        logic        prev_valid;
        prev_out   = {proto, sig, minute};
        prev_valid = valid;
        arm(p, s, dd);
        ignore_w = 1'b1;
        rdy = 1'b1;
        c0 = cyc;
        while (cyc < c0 + off) step();
        rdy = 1'b0;
        for (int i = 0; i < 3; i++) step();
        check({tag, " R9 strobe low after drop"}, 64'(strobe), 64'd0);
        for (int i = 0; i < 20; i++) step();
        check({tag, " R10 err count"}, 64'(n_err), 64'(exp_err));
        check({tag, " R10 done count"}, 64'(n_done), 64'(!exp_err));
        if (exp_err) begin
            check({tag, " R9 outputs kept"}, {proto, sig, minute}, prev_out);
            check({tag, " R9 valid kept"}, 64'(valid), 64'(prev_valid));
        end else begin
            check({tag, " R8 outputs"}, {proto, sig, minute}, {p, s, exp_minute(s, dd)});
        end
        ignore_w = 1'b0;
        for (int i = 0; i < 5; i++) step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        logic [59:0] rd;
        logic [2:0]  rp;
        logic        rs;
        seed_init = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check("R1 strobe", 64'(strobe), 64'd0);
        check("R1 done/err", {62'd0, done, err}, 64'd0);
        check("R1 outputs", {proto, sig, minute}, 64'd0);
        check("R1 valid", 64'(valid), 64'd0);

        // directed full frames and header-only frames
        do_read(3'b110, 1'b1, 60'hF0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, "full-a");
        do_read(3'b101, 1'b0, 60'h123_4567_89AB_CDEF, 1'b0, 1'b0, "hdr-a");
        do_read(3'b011, 1'b1, 60'h800_0000_0000_0001, 1'b0, 1'b0, "full-ends");
        // R7: level on data line before first strobe opposes the first bit
        do_read(3'b011, 1'b0, 60'd0, 1'b1, 1'b1, "R7 pre-high");
        do_read(3'b100, 1'b1, 60'hFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, "R7 pre-low");

        // R9: aborts in wake-up, in the header and in the data bits
        do_drop(3'b111, 1'b1, 60'hABC_DEF0_1234_5678, 5, 1'b1, "R9 wake");
        do_drop(3'b010, 1'b1, 60'h555_5555_5555_5555, WAKE + 2 * HALF * 2, 1'b1, "R9 header");
        do_drop(3'b001, 1'b1, 60'h333_3333_3333_3333, WAKE + 2 * HALF * 20, 1'b1, "R9 data");
        // R10: drop seen on the completion edge, then one edge later
        do_drop(3'b110, 1'b0, 60'd0, WAKE + 2 * HALF * 4, 1'b1, "R10 same edge");
        do_drop(3'b110, 1'b0, 60'd0, WAKE + 2 * HALF * 4 + 1, 1'b0, "R10 one later");
        do_drop(3'b101, 1'b1, 60'h0F0_F0F0_F0F0_F0F0, WAKE + 2 * HALF * 64, 1'b1, "R10 full same edge");

        // random frames
        for (int k = 0; k < 24; k++) begin
            rp = 3'($urandom);
            rs = 1'($urandom);
            rd = {28'($urandom), 32'($urandom)};
            do_read(rp, rs, rd, 1'b0, 1'b0, "rand");
        end

        check("R3 strobe phase widths", 64'(width_bad), 64'd0);
        finish_run();
    end
endmodule